// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block sits beside an instruction decoder and rules on four privileged instructions: wait-for-interrupt and three address-translation fences. The fences are the supervisor fence, the hypervisor fence and the guest-physical hypervisor fence. For each request it looks at the current privilege level, whether the hart runs virtualized, and a small set of trap-control status bits. It then gives one verdict: allow the instruction, or raise a fault. A fault is either an illegal-instruction fault or a virtual-instruction fault.

The decision itself is combinational. The verdict is registered, so every valid request produces a single-cycle result one clock later. The result is a done strobe together with an allow flag, a halt request for wait-for-interrupt, a flush pulse for an allowed fence, or a fault flag with its exception cause code. The translation buffer and the wake-up logic that ends a halt are outside this block. They consume the halt and flush pulses.

Top module: `priv_insn_gate`

## Requirements
- R1: While rst_n is low, every output (done_o, allow_o, halt_req_o, flush_o, fault_o, cause_o) is zero.
- R2: A request sampled with req_valid high at a clock edge produces done_o high for exactly the following cycle. A cycle with req_valid low leaves every output zero in the next cycle.
- R3: Wait-for-interrupt (req_op 0) gives a virtual-instruction fault when virt_on is high, or when the privilege is S (cur_priv 1) and tw_bit is high.
- R4: In every other wait-for-interrupt case the result is halt_req_o and allow_o high. tw_bit has no effect outside privilege S.
- R5: The supervisor fence (req_op 1) gives an illegal-instruction fault when cur_priv is numerically below S (U is 0). It gives the same fault when the privilege is S and tvm_bit is high.
- R6: Apart from the R5 cases, the supervisor fence gives a virtual-instruction fault when hyp_present, virt_on and vtvm_bit are all high. Otherwise it flushes. With hyp_present low, vtvm_bit has no effect.
- R7: The hypervisor fence (req_op 2) gives a virtual-instruction fault at privilege S with virt_on high.
- R8: The hypervisor fence flushes at privilege M (cur_priv 3), or at S with virt_on low. Any other privilege gives an illegal-instruction fault. tvm_bit has no effect on it.
- R9: The guest-physical fence (req_op 3) first gives an illegal-instruction fault at privilege S with virt_on low and tvm_bit high. Otherwise it follows R7 and R8.
- R10: cause_o is 2 for an illegal-instruction fault and 22 for a virtual-instruction fault, and 0 whenever fault_o is low. flush_o and halt_req_o are never high together with fault_o. allow_o is high exactly when done_o is high and fault_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 0 wait-for-interrupt, 1 supervisor fence, 2 hypervisor fence, 3 guest-physical fence |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_on | input | 1 | Hart runs in virtualized mode |
| tw_bit | input | 1 | Trap wait-for-interrupt at S |
| tvm_bit | input | 1 | Trap translation management at S |
| vtvm_bit | input | 1 | Trap translation management in a virtualized guest |
| hyp_present | input | 1 | Hypervisor support is implemented |
| done_o | output | 1 | One-cycle strobe: a verdict is on the outputs |
| allow_o | output | 1 | Instruction may execute |
| halt_req_o | output | 1 | One-cycle halt request for wait-for-interrupt |
| flush_o | output | 1 | One-cycle translation-buffer flush pulse |
| fault_o | output | 1 | Instruction faults |
| cause_o | output | CAUSE_W | Exception cause code (2 or 22), 0 if no fault |

## Verification
Some cases are hard to reach because two rules compete for the same input combination. One is the guest-physical fence at S with translation trapping set: with virtualization off it must give the early illegal fault, but with virtualization on the virtual fault must win. Another is the supervisor fence in a virtualized guest, where the result turns on the hypervisor-present flag. The directed tasks set up each such pair back to back, changing only the one bit that separates them. They also place a no-request cycle after a flush, which shows that the pulses fall back to zero.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

  typedef enum logic [1:0] {
    OP_WFI    = 2'd0,
    OP_SFENCE = 2'd1,
    OP_HFENCE = 2'd2,
    OP_GFENCE = 2'd3
  } gate_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    V_FLUSH   = 2'd0,
    V_HALT    = 2'd1,
    V_ILLEGAL = 2'd2,
    V_VIRTUAL = 2'd3
  } verdict_e;

  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic       tw;
    logic       tvm;
    logic       vtvm;
    logic       hyp;
  } gate_ctx_t;

  localparam int ILLEGAL_CODE = 2;
  localparam int VIRTUAL_CODE = 22;

endpackage

// File: rtl/gate_wfi_rule.sv
module gate_wfi_rule
  import priv_gate_pkg::*;
(
  input  gate_ctx_t ctx,
  output verdict_e  verdict
);

  logic s_trapped;

  always_comb begin
    s_trapped = (ctx.priv == PRIV_S) && ctx.tw;
    if (s_trapped || ctx.virt) begin
      verdict = V_VIRTUAL;
    end else begin
      verdict = V_HALT;
    end
  end

endmodule

// File: rtl/gate_sfence_rule.sv
module gate_sfence_rule
  import priv_gate_pkg::*;
(
  input  gate_ctx_t ctx,
  output verdict_e  verdict
);

  logic too_low;
  logic s_trapped;
  logic guest_trapped;

  always_comb begin
    too_low       = ctx.priv < PRIV_S;
    s_trapped     = (ctx.priv == PRIV_S) && ctx.tvm;
    guest_trapped = ctx.hyp && ctx.virt && ctx.vtvm;
    if (too_low || s_trapped) begin
      verdict = V_ILLEGAL;
    end else if (guest_trapped) begin
      verdict = V_VIRTUAL;
    end else begin
      verdict = V_FLUSH;
    end
  end

endmodule

// File: rtl/gate_hfence_rule.sv
module gate_hfence_rule
  import priv_gate_pkg::*;
#(
  parameter bit GUEST_PHYS = 1'b0
) (
  input  gate_ctx_t ctx,
  output verdict_e  verdict
);

  verdict_e base_verdict;
  logic     in_guest_s;
  logic     host_ok;

  always_comb begin
    in_guest_s = (ctx.priv == PRIV_S) && ctx.virt;
    host_ok    = (ctx.priv == PRIV_M) || ((ctx.priv == PRIV_S) && !ctx.virt);
    if (in_guest_s) begin
      base_verdict = V_VIRTUAL;
    end else if (host_ok) begin
      base_verdict = V_FLUSH;
    end else begin
      base_verdict = V_ILLEGAL;
    end
  end

  generate
    if (GUEST_PHYS) begin : g_gphys
      logic early_trap;
      always_comb begin
        early_trap = (ctx.priv == PRIV_S) && !ctx.virt && ctx.tvm;
        verdict    = early_trap ? V_ILLEGAL : base_verdict;
      end
    end else begin : g_plain
      always_comb begin
        verdict = base_verdict;
      end
    end
  endgenerate

endmodule

// File: rtl/gate_result_reg.sv
module gate_result_reg
  import priv_gate_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  verdict_e           verdict,
  output logic               done_q,
  output logic               allow_q,
  output logic               halt_q,
  output logic               flush_q,
  output logic               fault_q,
  output logic [CAUSE_W-1:0] cause_q
);

  localparam logic [CAUSE_W-1:0] ILL_C  = CAUSE_W'(ILLEGAL_CODE);
  localparam logic [CAUSE_W-1:0] VIRT_C = CAUSE_W'(VIRTUAL_CODE);

  logic               done_n, allow_n, halt_n, flush_n, fault_n;
  logic [CAUSE_W-1:0] cause_n;
  logic               cause_en;

  always_comb begin
    done_n  = valid;
    halt_n  = valid && (verdict == V_HALT);
    flush_n = valid && (verdict == V_FLUSH);
    fault_n = valid && ((verdict == V_ILLEGAL) || (verdict == V_VIRTUAL));
    allow_n = halt_n || flush_n;
    if (!fault_n) begin
      cause_n = '0;
    end else if (verdict == V_VIRTUAL) begin
      cause_n = VIRT_C;
    end else begin
      cause_n = ILL_C;
    end
    cause_en = valid || fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      allow_q <= 1'b0;
      halt_q  <= 1'b0;
      flush_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= done_n;
      allow_q <= allow_n;
      halt_q  <= halt_n;
      flush_q <= flush_n;
      fault_q <= fault_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_n;
    end
  end

endmodule

// File: rtl/priv_insn_gate.sv
module priv_insn_gate
  import priv_gate_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [1:0]         cur_priv,
  input  logic               virt_on,
  input  logic               tw_bit,
  input  logic               tvm_bit,
  input  logic               vtvm_bit,
  input  logic               hyp_present,
  output logic               done_o,
  output logic               allow_o,
  output logic               halt_req_o,
  output logic               flush_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int N_FENCE = 2;

  gate_ctx_t ctx;
  verdict_e  wfi_v;
  verdict_e  sf_v;
  verdict_e  hf_v [N_FENCE];
  verdict_e  sel_v;

  always_comb begin
    ctx.priv = cur_priv;
    ctx.virt = virt_on;
    ctx.tw   = tw_bit;
    ctx.tvm  = tvm_bit;
    ctx.vtvm = vtvm_bit;
    ctx.hyp  = hyp_present;
  end

  gate_wfi_rule u_wfi (
    .ctx     (ctx),
    .verdict (wfi_v)
  );

  gate_sfence_rule u_sfence (
    .ctx     (ctx),
    .verdict (sf_v)
  );

  // index 0: plain hypervisor fence, index 1: guest-physical fence
  for (genvar gi = 0; gi < N_FENCE; gi++) begin : g_hf
    gate_hfence_rule #(
      .GUEST_PHYS (gi == 1)
    ) u_hf (
      .ctx     (ctx),
      .verdict (hf_v[gi])
    );
  end

  always_comb begin
    unique case (gate_op_e'(req_op))
      OP_WFI:    sel_v = wfi_v;
      OP_SFENCE: sel_v = sf_v;
      OP_HFENCE: sel_v = hf_v[0];
      OP_GFENCE: sel_v = hf_v[1];
      default:   sel_v = V_ILLEGAL;
    endcase
  end

  gate_result_reg #(
    .CAUSE_W (CAUSE_W)
  ) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .verdict (sel_v),
    .done_q  (done_o),
    .allow_q (allow_o),
    .halt_q  (halt_req_o),
    .flush_q (flush_o),
    .fault_q (fault_o),
    .cause_q (cause_o)
  );

endmodule

// File: rtl/priv_gate_chk.sv
module priv_gate_chk #(
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_op,
  input logic [1:0]         cur_priv,
  input logic               virt_on,
  input logic               tvm_bit,
  input logic               done_o,
  input logic               allow_o,
  input logic               halt_req_o,
  input logic               flush_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] cause_o
);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!done_o && !allow_o && !halt_req_o && !flush_o
                                && !fault_o && (cause_o == '0));
    end
  end

  a_r2_done_tracks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done_o == $past(req_valid)));

  a_r3_wfi_guest_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && virt_on)
    |=> (fault_o && cause_o == CAUSE_W'(22)));

  a_r5_sfence_user_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && cur_priv == 2'd0)
    |=> (fault_o && cause_o == CAUSE_W'(2)));

  a_r7_hfence_guest_s: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1] && cur_priv == 2'd1 && virt_on)
    |=> (fault_o && cause_o == CAUSE_W'(22)));

  a_r8_hfence_machine_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && cur_priv == 2'd3) |=> flush_o);

  a_r9_gfence_early_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3 && cur_priv == 2'd1 && !virt_on && tvm_bit)
    |=> (fault_o && cause_o == CAUSE_W'(2)));

  a_r10_no_pulse_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!flush_o && !halt_req_o && !allow_o));

  a_r10_cause_values: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (cause_o == CAUSE_W'(2) || cause_o == CAUSE_W'(22)));

  a_r10_cause_zero_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> (cause_o == '0));

  a_r10_allow_def: assert property (@(posedge clk) disable iff (!rst_n)
    allow_o == (done_o && !fault_o));

endmodule

bind priv_insn_gate priv_gate_chk #(
  .CAUSE_W (CAUSE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .cur_priv   (cur_priv),
  .virt_on    (virt_on),
  .tvm_bit    (tvm_bit),
  .done_o     (done_o),
  .allow_o    (allow_o),
  .halt_req_o (halt_req_o),
  .flush_o    (flush_o),
  .fault_o    (fault_o),
  .cause_o    (cause_o)
);

// File: tb/sim_priv_insn_gate.sv
`timescale 1ns/1ps
module sim_priv_insn_gate;
  import priv_gate_pkg::*;

  localparam int CW = 5;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [1:0]    cur_priv;
  logic          virt_on, tw_bit, tvm_bit, vtvm_bit, hyp_present;
  logic          done_o, allow_o, halt_req_o, flush_o, fault_o;
  logic [CW-1:0] cause_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  priv_insn_gate #(.CAUSE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .cur_priv(cur_priv), .virt_on(virt_on), .tw_bit(tw_bit), .tvm_bit(tvm_bit),
    .vtvm_bit(vtvm_bit), .hyp_present(hyp_present),
    .done_o(done_o), .allow_o(allow_o), .halt_req_o(halt_req_o),
    .flush_o(flush_o), .fault_o(fault_o), .cause_o(cause_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] pack_out();
    return {done_o, allow_o, halt_req_o, flush_o, fault_o, cause_o};
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual done/allow/halt/flush/fault/cause=%b expected=%b",
               req, act, exp);
    end
  endtask

  // one request, verdict sampled at the negedge after the registering edge
  task automatic run_vec(string req, logic [1:0] op, logic [1:0] p, logic v,
                         logic tw, logic tvm, logic vtvm, logic hyp,
                         verdict_e exp);
    logic [9:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; cur_priv = p; virt_on = v;
    tw_bit = tw; tvm_bit = tvm; vtvm_bit = vtvm; hyp_present = hyp;
    @(negedge clk);
    req_valid = 1'b0;
    case (exp)
      V_FLUSH:   e = {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0};
      V_HALT:    e = {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0};
      V_ILLEGAL: e = {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2};
      default:   e = {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd22};
    endcase
    check(req, pack_out(), e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b1; req_op = 2'd1; cur_priv = PRIV_M;
    virt_on = 1'b0; tw_bit = 1'b0; tvm_bit = 1'b0; vtvm_bit = 1'b0; hyp_present = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", pack_out(), 10'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle after reset", pack_out(), 10'd0);
  endtask

  task automatic t_wfi();
    run_vec("R3 wfi S with tw",       2'd0, PRIV_S, 0, 1, 0, 0, 0, V_VIRTUAL);
    run_vec("R3 wfi M virtualized",   2'd0, PRIV_M, 1, 0, 0, 0, 1, V_VIRTUAL);
    run_vec("R3 wfi U virtualized",   2'd0, PRIV_U, 1, 0, 0, 0, 1, V_VIRTUAL);
    run_vec("R4 wfi U no trap",       2'd0, PRIV_U, 0, 0, 0, 0, 0, V_HALT);
    run_vec("R4 wfi S tw clear",      2'd0, PRIV_S, 0, 0, 1, 1, 1, V_HALT);
    run_vec("R4 wfi M tw ignored",    2'd0, PRIV_M, 0, 1, 0, 0, 0, V_HALT);
  endtask

  task automatic t_sfence();
    run_vec("R5 sfence U",            2'd1, PRIV_U, 0, 0, 0, 0, 0, V_ILLEGAL);
    run_vec("R5 sfence S tvm",        2'd1, PRIV_S, 0, 0, 1, 0, 0, V_ILLEGAL);
    run_vec("R5 sfence S tvm guest",  2'd1, PRIV_S, 1, 0, 1, 1, 1, V_ILLEGAL);
    run_vec("R6 sfence M tvm",        2'd1, PRIV_M, 0, 0, 1, 0, 0, V_FLUSH);
    run_vec("R6 sfence guest vtvm",   2'd1, PRIV_S, 1, 0, 0, 1, 1, V_VIRTUAL);
    run_vec("R6 sfence no hyp",       2'd1, PRIV_S, 1, 0, 0, 1, 0, V_FLUSH);
    run_vec("R6 sfence guest vtvm0",  2'd1, PRIV_S, 1, 0, 0, 0, 1, V_FLUSH);
  endtask

  task automatic t_hfence();
    run_vec("R7 hfence S guest",      2'd2, PRIV_S, 1, 0, 0, 0, 1, V_VIRTUAL);
    run_vec("R8 hfence M",            2'd2, PRIV_M, 0, 0, 0, 0, 1, V_FLUSH);
    run_vec("R8 hfence S host",       2'd2, PRIV_S, 0, 0, 0, 0, 1, V_FLUSH);
    run_vec("R8 hfence S tvm ignored",2'd2, PRIV_S, 0, 0, 1, 0, 1, V_FLUSH);
    run_vec("R8 hfence U",            2'd2, PRIV_U, 0, 0, 0, 0, 1, V_ILLEGAL);
    run_vec("R8 hfence U guest",      2'd2, PRIV_U, 1, 0, 0, 0, 1, V_ILLEGAL);
  endtask

  task automatic t_gfence();
    run_vec("R9 gfence S host tvm",   2'd3, PRIV_S, 0, 0, 1, 0, 1, V_ILLEGAL);
    run_vec("R9 gfence S guest tvm",  2'd3, PRIV_S, 1, 0, 1, 0, 1, V_VIRTUAL);
    run_vec("R9 gfence M tvm",        2'd3, PRIV_M, 0, 0, 1, 0, 1, V_FLUSH);
    run_vec("R9 gfence S host",       2'd3, PRIV_S, 0, 0, 0, 0, 1, V_FLUSH);
    run_vec("R9 gfence U",            2'd3, PRIV_U, 0, 0, 1, 0, 1, V_ILLEGAL);
  endtask

  task automatic t_pulses();
    run_vec("R10 flush before idle",  2'd2, PRIV_M, 0, 0, 0, 0, 1, V_FLUSH);
    @(negedge clk);
    check("R2 flush pulse one cycle", pack_out(), 10'd0);
    run_vec("R10 fault before idle",  2'd1, PRIV_U, 0, 0, 0, 0, 0, V_ILLEGAL);
    @(negedge clk);
    check("R10 cause clears", pack_out(), 10'd0);
    run_vec("R4 halt before idle",    2'd0, PRIV_S, 0, 0, 0, 0, 0, V_HALT);
    @(negedge clk);
    check("R2 halt pulse one cycle", pack_out(), 10'd0);
  endtask

  initial begin
    t_reset();
    t_wfi();
    t_sfence();
    t_hfence();
    t_gfence();
    t_pulses();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule